// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that software drives through two 16-bit write registers: a control word and a service word. A slow timebase tick arrives every half second. Setting the enable flag starts the count from the programmed timeout. The enable flag stays set from then on. To keep the system alive, software writes the key pair `0x5555` then `0xAAAA` to the service register, and this reloads the count.

If the count runs out, the block issues a reset pulse. Software can also force a pulse at once by clearing either of two active-low request flags in the control word. The internal reset output and the external reset output are each driven by their own conditions. Two freeze flags stop the count while a debug-halt input or a low-power stop input is high.

Each pulse lasts a fixed number of clock cycles. When the pulse ends, the whole block returns to its reset state.

Control word layout:
- Bits 15:8 hold the timeout value N. The time to expiry is (N+1) × 0.5 s.
- Bits 7:6 always read as 0.
- Bit 5 selects whether expiry also drives the external reset.
- Bit 4 is the active-low external reset request.
- Bit 3 is the active-low internal reset request.
- Bit 2 is the stop freeze flag.
- Bit 1 is the debug freeze flag.
- Bit 0 is the enable flag.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the control readback is `0x0018` and both reset outputs are low.
- R2: A control write with bit 0 = 0 does not clear an enable flag that is already set.
- R3: When enabled with timeout field N and never serviced, `int_rst_o` rises on the (N+1)-th accepted tick and not before.
- R4: Writing `0x5555` and then `0xAAAA` to the service address (`wr_addr`=1) reloads the count with the timeout field, so N+1 more ticks are needed before expiry.
- R5: A service sequence that is wrong, out of order, or interrupted (for example `0xAAAA` alone, or `0x5555`, `0x1234`, `0xAAAA`) does not reload the count.
- R6: A control write with bit 3 = 0 raises `int_rst_o` on the next clock edge and leaves `ext_rst_o` low when bit 4 = 1.
- R7: A control write with bit 4 = 0 raises `ext_rst_o` on the next clock edge and leaves `int_rst_o` low when bit 3 = 1.
- R8: On expiry, `int_rst_o` is always raised. `ext_rst_o` is raised as well only if control bit 5 is 1.
- R9: Ticks received while the enable flag is 0 have no effect on the count.
- R10: Ticks are ignored while `dbg_halt_i` is high and bit 1 is set, or while `stop_i` is high and bit 2 is set. Otherwise the halt inputs have no effect.
- R11: A reset output stays high for exactly PULSE_CYC clock cycles. After that, the control readback returns to `0x0018`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = service word |
| wr_data | input | 16 | Write data |
| tick_i | input | 1 | Half-second timebase tick |
| dbg_halt_i | input | 1 | Debug halt indication |
| stop_i | input | 1 | Low-power stop indication |
| ctrl_rd_o | output | 16 | Control word readback |
| int_rst_o | output | 1 | Internal reset pulse, active high |
| ext_rst_o | output | 1 | External reset pulse, active high |

## Verification
The bench counts ticks up to the exact expiry edge. This catches an off-by-one in the timeout, which would fire one tick early or one tick late. It then feeds broken key sequences whose last word is the correct second key. A checker that remembers a half-finished sequence, or that accepts `0xAAAA` on its own, would reload the count and miss the expected expiry. The bench also drives ticks while the block is disabled and while each freeze condition is active, and it clears the enable flag by a write. A design that counted those ticks, or let the flag drop, would fire early or never fire. Finally, it measures the pulse width and the control word after the pulse. This exposes a pulse that is stretched or cut short, or a control word that is not restored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int CTRL_W = 16;
   localparam int TMO_W  = 8;

   typedef struct packed {
      logic [TMO_W-1:0] tmo;
      logic [1:0]       rsvd;
      logic             exp_ext;
      logic             ext_n;
      logic             sw_n;
      logic             stop_frz;
      logic             dbg_frz;
      logic             en;
   } wdt_ctrl_t;

   localparam wdt_ctrl_t CTRL_DEF = '{tmo: '0, rsvd: 2'b00, exp_ext: 1'b0,
                                      ext_n: 1'b1, sw_n: 1'b1, stop_frz: 1'b0,
                                      dbg_frz: 1'b0, en: 1'b0};
endpackage

// File: rtl/wdt_keychk.sv
module wdt_keychk #(
   parameter int          KEY_W      = 16,
   parameter logic [15:0] KEY_FIRST  = 16'h5555,
   parameter logic [15:0] KEY_SECOND = 16'hAAAA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             svc_wr,
   input  logic [KEY_W-1:0] svc_data,
   output logic             reload
);
   logic armed_q;

   assign reload = svc_wr && armed_q && (svc_data == KEY_SECOND[KEY_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (clr) begin
         armed_q <= 1'b0;
      end else if (svc_wr) begin
         armed_q <= (svc_data == KEY_FIRST[KEY_W-1:0]);
      end
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign expire = step && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
   parameter int PULSE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_int,
   input  logic trig_ext,
   output logic int_q,
   output logic ext_q,
   output logic busy,
   output logic done
);
   localparam int LW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   logic [LW-1:0] left_q;

   assign busy = int_q || ext_q;
   assign done = busy && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= 1'b0;
         ext_q  <= 1'b0;
         left_q <= '0;
      end else if (!busy) begin
         if (trig_int || trig_ext) begin
            int_q  <= trig_int;
            ext_q  <= trig_ext;
            left_q <= LW'(PULSE_CYC - 1);
         end
      end else if (done) begin
         int_q <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
   import wdt_pkg::*;
#(
   parameter int          PULSE_CYC  = 4,
   parameter logic [15:0] KEY_FIRST  = 16'h5555,
   parameter logic [15:0] KEY_SECOND = 16'hAAAA,
   parameter bit          TICK_EDGE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              tick_i,
   input  logic              dbg_halt_i,
   input  logic              stop_i,
   output logic [CTRL_W-1:0] ctrl_rd_o,
   output logic              int_rst_o,
   output logic              ext_rst_o
);
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if (CTRL_W != $bits(wdt_ctrl_t)) begin : g_bad_ctrl
      $error("control struct width mismatch");
   end

   wdt_ctrl_t ctrl_q;
   wdt_ctrl_t wr_ctrl;
   logic      tick_p, busy, done, expire, reload;
   logic      ctrl_wr, svc_wr, en_start, frozen, step;
   logic      trig_int, trig_ext;

   if (TICK_EDGE) begin : g_tick_edge
      logic tick_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_d <= 1'b0;
         else        tick_d <= tick_i;
      end
      assign tick_p = tick_i && !tick_d;
   end else begin : g_tick_level
      assign tick_p = tick_i;
   end

   assign wr_ctrl  = wdt_ctrl_t'(wr_data);
   assign ctrl_wr  = wr_en && !wr_addr && !busy;
   assign svc_wr   = wr_en &&  wr_addr && !busy;
   assign en_start = ctrl_wr && wr_ctrl.en && !ctrl_q.en;
   assign frozen   = (ctrl_q.dbg_frz && dbg_halt_i) || (ctrl_q.stop_frz && stop_i);
   assign step     = tick_p && ctrl_q.en && !frozen && !busy;

   assign trig_int = (ctrl_wr && !wr_ctrl.sw_n) || expire;
   assign trig_ext = (ctrl_wr && !wr_ctrl.ext_n) || (expire && ctrl_q.exp_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_DEF;
      end else if (done) begin
         ctrl_q <= CTRL_DEF;
      end else if (ctrl_wr) begin
         ctrl_q      <= wr_ctrl;
         ctrl_q.rsvd <= 2'b00;
         ctrl_q.en   <= ctrl_q.en || wr_ctrl.en;
      end
   end

   wdt_keychk #(.KEY_W(CTRL_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
      .clk(clk), .rst_n(rst_n), .clr(done), .svc_wr(svc_wr),
      .svc_data(wr_data), .reload(reload)
   );

   wdt_countdown #(.CNT_W(TMO_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(done), .load(en_start || reload),
      .load_val(en_start ? wr_ctrl.tmo : ctrl_q.tmo), .step(step), .expire(expire)
   );

   wdt_rstpulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig_int(trig_int), .trig_ext(trig_ext),
      .int_q(int_rst_o), .ext_q(ext_rst_o), .busy(busy), .done(done)
   );

   assign ctrl_rd_o = ctrl_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
   parameter int PULSE_CYC = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_addr,
   input logic [15:0] wr_data,
   input logic        tick_i,
   input logic [15:0] ctrl_rd_o,
   input logic        int_rst_o,
   input logic        ext_rst_o
);
   localparam int RW = $clog2(PULSE_CYC + 2) + 1;

   logic [RW-1:0] run_q;
   logic          idle;

   assign idle = !int_rst_o && !ext_rst_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (int_rst_o)     run_q <= run_q + 1'b1;
      else                    run_q <= '0;
   end

   // R2
   en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd_o[0] && idle) |=> ctrl_rd_o[0]);

   // R6
   sw_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && wr_en && !wr_addr && !wr_data[3]) |=> int_rst_o);

   // R7
   ext_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && wr_en && !wr_addr && !wr_data[4]) |=> ext_rst_o);

   // R3
   int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_rst_o) |-> ($past(tick_i && ctrl_rd_o[0]) ||
                            $past(wr_en && !wr_addr && !wr_data[3])));

   // R11
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_rst_o |-> (run_q < RW'(PULSE_CYC)));

   // R11
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst_o || ext_rst_o) |-> (ctrl_rd_o == 16'h0018));
endmodule

bind svc_watchdog wdt_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .tick_i(tick_i), .ctrl_rd_o(ctrl_rd_o),
   .int_rst_o(int_rst_o), .ext_rst_o(ext_rst_o)
);

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb;
   localparam int PC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tick_i = 1'b0;
   logic        dbg_halt_i = 1'b0;
   logic        stop_i = 1'b0;
   logic [15:0] ctrl_rd_o;
   logic        int_rst_o, ext_rst_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   svc_watchdog #(.PULSE_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick_i(tick_i), .dbg_halt_i(dbg_halt_i),
      .stop_i(stop_i), .ctrl_rd_o(ctrl_rd_o), .int_rst_o(int_rst_o),
      .ext_rst_o(ext_rst_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic service();
      wr(1'b1, 16'h5555);
      wr(1'b1, 16'hAAAA);
   endtask

   // measures the pulse still running and checks restore (R11)
   task automatic finish_pulse(input int seen);
      int n = seen;
      while (int_rst_o || ext_rst_o) begin
         n++;
         @(negedge clk);
         if (n > 50) break;
      end
      chk("R11 width", 16'(n), 16'(PC));
      chk("R11 restore", ctrl_rd_o, 16'h0018);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 ctrl", ctrl_rd_o, 16'h0018);
      chk("R1 outs", {14'b0, int_rst_o, ext_rst_o}, 16'h0);
   endtask

   task automatic t_expiry();
      tick(10);
      chk("R9 disabled ticks", {15'b0, int_rst_o}, 16'h0);
      wr(1'b0, 16'h0219);
      tick(2);
      chk("R3 before N+1", {15'b0, int_rst_o}, 16'h0);
      tick(1);
      chk("R3 at N+1", {15'b0, int_rst_o}, 16'h1);
      chk("R8 no ext", {15'b0, ext_rst_o}, 16'h0);
      finish_pulse(0);
   endtask

   task automatic t_sticky();
      wr(1'b0, 16'h0319);
      wr(1'b0, 16'h0318);
      chk("R2 sticky", ctrl_rd_o, 16'h0319);
      do_reset();
   endtask

   task automatic t_service();
      wr(1'b0, 16'h0339);
      tick(3);
      service();
      tick(3);
      chk("R4 reloaded", {15'b0, int_rst_o}, 16'h0);
      tick(1);
      chk("R4 expiry", {15'b0, int_rst_o}, 16'h1);
      chk("R8 ext on expiry", {15'b0, ext_rst_o}, 16'h1);
      finish_pulse(0);
   endtask

   task automatic t_badkey();
      wr(1'b0, 16'h0219);
      tick(2);
      wr(1'b1, 16'hAAAA);
      wr(1'b1, 16'h5555);
      wr(1'b1, 16'h1234);
      wr(1'b1, 16'hAAAA);
      chk("R5 no early", {15'b0, int_rst_o}, 16'h0);
      tick(1);
      chk("R5 no reload", {15'b0, int_rst_o}, 16'h1);
      finish_pulse(0);
   endtask

   task automatic t_freeze();
      wr(1'b0, 16'h021B);
      dbg_halt_i = 1'b1;
      tick(5);
      chk("R10 dbg frozen", {15'b0, int_rst_o}, 16'h0);
      dbg_halt_i = 1'b0;
      stop_i = 1'b1;
      tick(2);
      chk("R10 stop unselected", {15'b0, int_rst_o}, 16'h0);
      tick(1);
      chk("R10 stop counts", {15'b0, int_rst_o}, 16'h1);
      finish_pulse(0);
      wr(1'b0, 16'h021D);
      tick(5);
      chk("R10 stop frozen", {15'b0, int_rst_o}, 16'h0);
      stop_i = 1'b0;
      tick(3);
      chk("R10 resume", {15'b0, int_rst_o}, 16'h1);
      finish_pulse(0);
   endtask

   task automatic t_forced();
      wr(1'b0, 16'h0010);
      chk("R6 int", {15'b0, int_rst_o}, 16'h1);
      chk("R6 ext low", {15'b0, ext_rst_o}, 16'h0);
      finish_pulse(0);
      wr(1'b0, 16'h0008);
      chk("R7 ext", {15'b0, ext_rst_o}, 16'h1);
      chk("R7 int low", {15'b0, int_rst_o}, 16'h0);
      finish_pulse(0);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_expiry();
      t_sticky();
      t_service();
      t_badkey();
      t_freeze();
      t_forced();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule